// File: doc/BRIEF.md
# Dual-Converter Serial Result Framer

This block is the device-side output port of a converter pair that samples two inputs at the same instant. A host frames each access with an active-low select and supplies a serial clock. When the select falls, the block latches both 12-bit results (modelled as parallel inputs), the channel-pair choice and the coding choice. It then shifts a 16-bit word out on each of two data pins, one pin per converter, with each bit advancing on a falling serial-clock edge. If the host keeps the select low for a second group of 16 clocks, the other converter's word follows on the same pin, so one serial port can collect both results.

All inputs are taken as already synchronous to the block clock `clk`. Select and serial-clock edges are found by comparing each input with its value one `clk` earlier. The controller has three named states. `ST_IDLE` means no frame and pins released. `ST_SHIFT` means a frame is in progress. `ST_TAIL` means all 32 bits are sent and the select is still low. The transitions are as follows. START (`ST_IDLE`→`ST_SHIFT`) fires on a select falling edge. FINISH (`ST_SHIFT`→`ST_TAIL`) fires on the falling clock edge that ends bit 31. ABORT (`ST_SHIFT`→`ST_IDLE`) and RELEASE (`ST_TAIL`→`ST_IDLE`) both fire whenever the select is high.

The coding choice is checked a second time at the eighth falling serial-clock edge of the frame. If its level differs from the latched one, the coding is swapped for every MSB not yet sent. In a 32-clock frame that MSB belongs to the chained word.

Top module: `adc_pair_framer`

## Requirements
- R1: Each word is 16 bits, sent first bit first. Position 0 is a zero. Position 1 is the converter identity (0 = A, 1 = B). Position 2 is the latched pair select (0 = channel 1, 1 = channel 2). Position 3 is the latched coding select. Positions 4 to 15 are the 12-bit result, MSB first.
- R2: One `clk` cycle after the select is first sampled low in `ST_IDLE`, `sdo_oe` is 1 and both pins show the leading zero. This happens before any serial-clock edge.
- R3: The bit position advances by exactly one on each falling serial-clock edge (sclk sampled 1, then 0) while shifting. Otherwise the pins hold their value.
- R4: In the first 16 bits, `sdo_a` carries converter A's word and `sdo_b` carries converter B's word, both from the same latched pair of results.
- R5: Bits 16 to 31 of a frame carry the other converter's word: B's word on `sdo_a` and A's word on `sdo_b`. After the 32nd falling edge, both pins drive 0 with `sdo_oe` high until the select rises.
- R6: `pair_sel`, `range_sel`, `result_a` and `result_b` are latched at the select falling edge. Later changes to them do not alter the frame, except as R8 states.
- R7: A latched coding select of 0 sends the result as straight binary. A value of 1 sends two's complement, which is the straight code with its MSB inverted.
- R8: If `range_sel` differs from its latched value at the eighth falling serial-clock edge, the coding used for every MSB sent after that edge is swapped. Position 3 (status) is not affected.
- R9: Whenever the select is sampled high, `sdo_oe` and both pins are 0 from the next cycle. Serial-clock edges are ignored while the select is high. The next frame starts again at position 0.
- R10: While reset is asserted and just after it, `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; bits advance on its falling edge |
| pair_sel | input | 1 | Channel pair select, latched at select fall |
| range_sel | input | 1 | Coding select, latched at select fall, rechecked at the 8th edge |
| result_a | input | 12 | Converter A result |
| result_b | input | 12 | Converter B result |
| sdo_a | output | 1 | Serial data pin A (0 when released) |
| sdo_b | output | 1 | Serial data pin B (0 when released) |
| sdo_oe | output | 1 | Output enable for both pins (0 = high impedance) |

## Verification
The coding swap is the hardest case to reach. It needs a full 32-clock frame in which `range_sel` is moved after the latch and before the eighth falling edge. Its only visible effect is then the MSB of the chained word, 13 bits later. The stimulus therefore runs chained frames with and without such a change, and with both latched levels. It also runs a frame where the level changes only after the eighth edge, which must have no effect. A behavioural reference model is compared on every clock, and the collected words are checked against independently computed values.

// File: rtl/adc_framer_pkg.sv
package adc_framer_pkg;
    localparam int STAT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } frm_state_t;
endpackage

// File: rtl/adc_word_fmt.sv
module adc_word_fmt #(
    parameter int DATA_W = 12,
    localparam int WORD_W = 1 + adc_framer_pkg::STAT_W + DATA_W
) (
    input  logic              conv_id,
    input  logic              pair_q,
    input  logic              range_q,
    input  logic              twos,
    input  logic [DATA_W-1:0] res,
    output logic [WORD_W-1:0] word
);
    logic [DATA_W-1:0] coded;

    // two's complement of an offset code: flip the MSB only
    always_comb begin
        coded = res ^ {twos, {(DATA_W-1){1'b0}}};
        word  = {1'b0, conv_id, pair_q, range_q, coded};
    end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_framer_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int FRAME_W   = 32,
    parameter int FLIP_EDGE = 8,
    localparam int IDX_W    = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              pair_sel,
    input  logic              range_sel,
    input  logic [DATA_W-1:0] result_a,
    input  logic [DATA_W-1:0] result_b,
    output frm_state_t        state,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              sclk_fall,
    output logic              pair_q,
    output logic              range_q,
    output logic              flip_q,
    output logic [DATA_W-1:0] res_a_q,
    output logic [DATA_W-1:0] res_b_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
    localparam logic [IDX_W-1:0] FLIP_IDX = IDX_W'(FLIP_EDGE - 1);

    frm_state_t state_nx;
    logic       cs_q;
    logic       sclk_q;
    logic       start;

    assign sclk_fall = sclk_q & ~sclk;
    assign start     = (state == ST_IDLE) & cs_q & ~cs_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            state  <= state_nx;
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    // transitions: START, FINISH, ABORT, RELEASE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (cs_n)                                 state_nx = ST_IDLE;
                else if (sclk_fall && bit_idx == LAST_IDX) state_nx = ST_TAIL;
            end
            ST_TAIL:  if (cs_n) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // capture, bit position and mid-frame coding swap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            pair_q  <= 1'b0;
            range_q <= 1'b0;
            flip_q  <= 1'b0;
            res_a_q <= '0;
            res_b_q <= '0;
        end else if (start) begin
            bit_idx <= '0;
            pair_q  <= pair_sel;
            range_q <= range_sel;
            flip_q  <= 1'b0;
            res_a_q <= result_a;
            res_b_q <= result_b;
        end else if (state == ST_SHIFT && !cs_n && sclk_fall) begin
            if (bit_idx == FLIP_IDX && range_sel != range_q)
                flip_q <= 1'b1;
            if (bit_idx != LAST_IDX)
                bit_idx <= bit_idx + 1'b1;
        end
    end

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (bit_idx == '0 && !flip_q && state == ST_SHIFT));

    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !cs_n && sclk_fall && bit_idx != LAST_IDX)
            |=> (bit_idx == $past(bit_idx) + 1'b1));
endmodule

// File: rtl/adc_pair_framer.sv
module adc_pair_framer
    import adc_framer_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int FLIP_EDGE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              pair_sel,
    input  logic              range_sel,
    input  logic [DATA_W-1:0] result_a,
    input  logic [DATA_W-1:0] result_b,
    output logic              sdo_a,
    output logic              sdo_b,
    output logic              sdo_oe
);
    localparam int WORD_W  = 1 + STAT_W + DATA_W;
    localparam int FRAME_W = 2 * WORD_W;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int N_CONV  = 2;

    frm_state_t        state;
    logic [IDX_W-1:0]  bit_idx;
    logic              sclk_fall;
    logic              pair_q, range_q, flip_q;
    logic [DATA_W-1:0] res_a_q, res_b_q;
    logic [IDX_W-1:0]  sel;
    logic [WORD_W-1:0] word_1st [N_CONV];
    logic [WORD_W-1:0] word_2nd [N_CONV];
    logic [FRAME_W-1:0] frame   [N_CONV];

    adc_frame_ctrl #(
        .DATA_W(DATA_W), .FRAME_W(FRAME_W), .FLIP_EDGE(FLIP_EDGE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .pair_sel(pair_sel), .range_sel(range_sel),
        .result_a(result_a), .result_b(result_b),
        .state(state), .bit_idx(bit_idx), .sclk_fall(sclk_fall),
        .pair_q(pair_q), .range_q(range_q), .flip_q(flip_q),
        .res_a_q(res_a_q), .res_b_q(res_b_q)
    );

    // the first word's MSB leaves before the swap edge; the chained one may not
    for (genvar c = 0; c < N_CONV; c++) begin : g_conv
        adc_word_fmt #(.DATA_W(DATA_W)) u_fmt_1st (
            .conv_id(c[0]), .pair_q(pair_q), .range_q(range_q),
            .twos(range_q ^ flip_q),
            .res((c == 0) ? res_a_q : res_b_q),
            .word(word_1st[c])
        );
        adc_word_fmt #(.DATA_W(DATA_W)) u_fmt_2nd (
            .conv_id(~c[0]), .pair_q(pair_q), .range_q(range_q),
            .twos(range_q ^ flip_q),
            .res((c == 0) ? res_b_q : res_a_q),
            .word(word_2nd[c])
        );
        assign frame[c] = {word_1st[c], word_2nd[c]};
    end

    assign sel = IDX_W'(FRAME_W - 1) - bit_idx;

    // outputs from state
    always_comb begin
        sdo_oe = 1'b0;
        sdo_a  = 1'b0;
        sdo_b  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SHIFT: begin
                sdo_oe = 1'b1;
                sdo_a  = frame[0][sel];
                sdo_b  = frame[1][sel];
            end
            ST_TAIL: sdo_oe = 1'b1;
            default: ;
        endcase
    end

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!sdo_oe && !sdo_a && !sdo_b));

    assert_lead_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (!sdo_a && !sdo_b));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !cs_n && !sclk_fall) |=> ($stable(sdo_a) && $stable(sdo_b)));

    assert_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL && !cs_n) |=> (sdo_oe && !sdo_a && !sdo_b));
endmodule

// File: tb/adc_pair_framer_bench.sv
module adc_pair_framer_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic pair_sel = 1'b0;
    logic range_sel = 1'b0;
    logic [11:0] result_a = '0;
    logic [11:0] result_b = '0;
    logic sdo_a, sdo_b, sdo_oe;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    adc_pair_framer u_adc_pair_framer (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .pair_sel(pair_sel), .range_sel(range_sel),
        .result_a(result_a), .result_b(result_b),
        .sdo_a(sdo_a), .sdo_b(sdo_b), .sdo_oe(sdo_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // reference model state
    int m_active = 0, m_tail = 0, m_idx = 0, m_flip = 0;
    int m_pair = 0, m_rng = 0, m_pcs = 1, m_psclk = 0;
    int m_ra = 0, m_rb = 0;

    function automatic int ref_bit(int conv, int res, int pos, int twos);
        if (pos == 0) return 0;
        if (pos == 1) return conv;
        if (pos == 2) return m_pair;
        if (pos == 3) return m_rng;
        if (pos == 4) return ((res >> 11) & 1) ^ twos;
        return (res >> (15 - pos)) & 1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_active = 0; m_tail = 0; m_pcs = 1; m_psclk = 0;
        end else begin
            if (cs_n) begin
                m_active = 0; m_tail = 0;
            end else if (m_pcs == 1 && !m_active) begin
                m_active = 1; m_tail = 0; m_idx = 0; m_flip = 0;
                m_pair = pair_sel; m_rng = range_sel;
                m_ra = result_a; m_rb = result_b;
            end else if (m_active && !m_tail && m_psclk == 1 && sclk == 0) begin
                if (m_idx == 7 && range_sel != m_rng) m_flip = 1;
                if (m_idx == 31) m_tail = 1; else m_idx++;
            end
            m_pcs = cs_n;
            m_psclk = sclk;
        end
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int ea, eb, eoe, tw;
            tw = m_rng ^ m_flip;
            eoe = m_active;
            ea = 0; eb = 0;
            if (m_active && !m_tail) begin
                if (m_idx < 16) begin
                    ea = ref_bit(0, m_ra, m_idx, m_rng);
                    eb = ref_bit(1, m_rb, m_idx, m_rng);
                end else begin
                    ea = ref_bit(1, m_rb, m_idx - 16, tw);
                    eb = ref_bit(0, m_ra, m_idx - 16, tw);
                end
            end
            if (!m_active)
                check("R9 released pins", {sdo_oe, sdo_a, sdo_b}, 0);
            else if (m_tail)
                check("R5 tail", {sdo_oe, sdo_a, sdo_b}, {eoe[0], 2'b00});
            else if (m_idx >= 16)
                check("R5 chained bit", {sdo_oe, sdo_a, sdo_b}, {eoe[0], ea[0], eb[0]});
            else
                check("R1 R4 word bit", {sdo_oe, sdo_a, sdo_b}, {eoe[0], ea[0], eb[0]});
        end
    end

    function automatic logic [15:0] exp_word(bit conv, logic [11:0] res, bit pair, bit rng, bit twos);
        return {1'b0, conv, pair, rng, res[11] ^ twos, res[10:0]};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] wa, wb;

    // one frame; chg_at: pulse index before which range_sel is toggled (-1 none)
    task automatic frame(input logic [11:0] ra, input logic [11:0] rb, input bit pair,
                         input bit rng, input int nclk, input int chg_at);
        bit twos2;
        result_a = ra; result_b = rb; pair_sel = pair; range_sel = rng;
        cs_n = 1'b0;
        tick(2);
        check("R2 lead zero", {sdo_oe, sdo_a, sdo_b}, 3'b100);
        // R6: disturb latched inputs after the capture
        result_a = ~ra; result_b = ~rb; pair_sel = ~pair;
        wa = '0; wb = '0;
        for (int i = 0; i < nclk; i++) begin
            if (i == chg_at) range_sel = ~rng;
            wa = {wa[30:0], sdo_a}; wb = {wb[30:0], sdo_b};
            sclk = 1'b1; tick(2);
            sclk = 1'b0; tick(2);
        end
        twos2 = rng ^ (chg_at >= 0 && chg_at < 8);
        if (nclk == 16) begin
            check("R1 R7 word A", wa[15:0], exp_word(0, ra, pair, rng, rng));
            check("R4 word B", wb[15:0], exp_word(1, rb, pair, rng, rng));
        end else if (nclk == 32) begin
            check("R6 R7 first word A", wa[31:16], exp_word(0, ra, pair, rng, rng));
            check("R5 R8 chained on A", wa[15:0], exp_word(1, rb, pair, rng, twos2));
            check("R5 R8 chained on B", wb[15:0], exp_word(0, ra, pair, rng, twos2));
            check("R5 tail zero", {sdo_oe, sdo_a, sdo_b}, 3'b100);
        end
        cs_n = 1'b1;
        tick(2);
        check("R9 released after frame", {sdo_oe, sdo_a, sdo_b}, 0);
    endtask

    initial begin
        tick(3);
        check("R10 reset oe", sdo_oe, 0);
        rst_n = 1'b1;
        tick(2);
        check("R10 after reset oe", sdo_oe, 0);

        frame(12'hA5C, 12'h3E1, 0, 0, 16, -1);   // straight, channel 1
        frame(12'h80F, 12'h07A, 1, 1, 16, -1);   // two's complement, channel 2
        frame(12'hFFF, 12'h000, 0, 0, 32, -1);   // chained, no swap
        frame(12'h123, 12'hC40, 1, 0, 32, 3);    // R8 swap to two's complement
        frame(12'h9A6, 12'h5B7, 0, 1, 32, 2);    // R8 swap to straight
        frame(12'h456, 12'h89A, 1, 1, 32, 12);   // change after 8th edge: no swap

        // R9 abort mid-frame, then clocks while released are ignored
        result_a = 12'h777; result_b = 12'h111; cs_n = 1'b0;
        tick(2);
        for (int i = 0; i < 10; i++) begin
            sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
        end
        cs_n = 1'b1;
        tick(2);
        check("R9 abort releases", {sdo_oe, sdo_a, sdo_b}, 0);
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
            check("R9 clocks ignored while high", sdo_oe, 0);
        end
        frame(12'h5A5, 12'hA5A, 0, 1, 16, -1);   // restart at position 0

        // R3: select low, clock idle: pins hold
        result_a = 12'hF00; result_b = 12'h0F0; pair_sel = 1; range_sel = 0;
        cs_n = 1'b0; tick(2);
        sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
        sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
        tick(10);
        check("R3 hold at position 2 (pair bit)", {sdo_a, sdo_b}, 2'b11);
        cs_n = 1'b1; tick(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule